// File: doc/BRIEF.md
# Multi-Cycle Integer Divide and Remainder Unit

This block performs 32-bit integer division for the multiply/divide path of an in-order processor execution unit. It serves four operations: signed and unsigned quotient, and signed and unsigned remainder. The requester raises `reqValid` with both operands and a one-hot operation code, and keeps them steady. The request and its result complete together in one handshake. `reqReady` rises only in the cycle where the result is taken, so the request is retired at the same edge as the result.

A general division runs a non-restoring loop on operand magnitudes. The loop makes one quotient bit per clock. A correction step and a sign-fixing step follow it. Two cases skip the loop and answer in the cycle of the request: a zero divisor, and the signed overflow of the most negative value divided by minus one.

A `flush` pulse drops any operation in progress. The unit keeps the quotient and remainder of its last full computation. A request marked as chained (`reqChain`) returns one of the stored values at once, with no new computation. A flush cancels that stored pair.

Top module: `int_divider`

## Requirements
- R1: `reqOp` is one-hot: bit 0 selects signed quotient, bit 1 unsigned quotient, bit 2 signed remainder, bit 3 unsigned remainder. A signed quotient is rounded toward zero. An unsigned quotient is the floor of the unsigned operands.
- R2: A remainder satisfies dividend = quotient × divisor + remainder. For a signed remainder it carries the sign of the dividend.
- R3: A computed result first appears (`rspValid` high) in the 36th cycle, counting the cycle where the idle unit first sees the request as the first. `rspValid` stays low in the cycles before it.
- R4: With a zero divisor, both quotient operations return 0xFFFFFFFF. Both remainder operations return the dividend unchanged.
- R5: For the signed operations, 0x80000000 divided by 0xFFFFFFFF returns 0x80000000 as quotient and 0 as remainder. The unsigned operations on the same operands are computed normally.
- R6: The cases of R4 and R5 are answered in the same cycle as the request, with no busy period.
- R7: While `rspReady` is low, a presented result stays valid and unchanged. `reqReady` is high exactly when `rspValid` and `rspReady` are both high.
- R8: A `flush` held for one cycle abandons a busy or finished operation. `rspValid` is low during the flush cycle, and no result follows it.
- R9: A chained request (`reqChain` high) arriving after a computed result was handed over returns at once a stored value from that computation. Quotient operations get the stored quotient and remainder operations get the stored remainder.
- R10: After a flush, a chained request is computed in full with the R3 latency.
- R11: `rspValid` is never high without `reqValid`. After reset, `rspValid` and `reqReady` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present; held until `reqReady` |
| reqReady | output | 1 | Request retired together with the result |
| reqDividend | input | DATA_W | Dividend |
| reqDivisor | input | DATA_W | Divisor |
| reqOp | input | 4 | One-hot operation code (see R1) |
| reqChain | input | 1 | Request may reuse the last computed result |
| flush | input | 1 | Abort pulse |
| rspValid | output | 1 | Result valid |
| rspReady | input | 1 | Consumer takes the result |
| rspData | output | DATA_W | Quotient or remainder |

## Verification
The bench builds the unit with its default width of 32 bits. At that width the loop runs 32 steps and the overall latency is exactly 36 cycles. The most negative operand 0x80000000 and the all-ones divisor are then the genuine overflow pair, and unsigned magnitudes reach the top bit of the partial remainder. A behavioural model follows every request cycle by cycle. It covers stalls on the result side, flushes while busy and while finished, and chained reuse before and after a flush.

// File: rtl/int_div_pkg.sv
`timescale 1ns/1ps
package int_div_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } divState_t;

  typedef enum logic [1:0] {
    SEL_CALC    = 2'd0,
    SEL_SPECIAL = 2'd1,
    SEL_REUSE   = 2'd2
  } resSel_t;

  typedef struct packed {
    logic load;
    logic step;
    logic fix;
    logic finish;
  } divStrobes_t;

endpackage

// File: rtl/int_div_ctrl.sv
`timescale 1ns/1ps
module int_div_ctrl
  import int_div_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic        reqChain,
  input  logic        isSpecial,
  input  logic        flush,
  input  logic        rspReady,
  output divStrobes_t strobes,
  output resSel_t     resSel,
  output logic        rspValid,
  output logic        reqReady,
  output divState_t   state
);
  localparam int LAST  = DATA_W + 1;
  localparam int CNT_W = $clog2(LAST + 1);

  logic [CNT_W-1:0] cnt;
  logic reuseOk;
  logic idle, useSpecial, useReuse, start, handshake;

  assign idle       = (state == ST_IDLE);
  assign useSpecial = idle & reqValid & isSpecial & ~flush;
  assign useReuse   = idle & reqValid & ~isSpecial & reqChain & reuseOk & ~flush;
  assign start      = idle & reqValid & ~isSpecial & ~(reqChain & reuseOk) & ~flush;

  assign rspValid  = useSpecial | useReuse | ((state == ST_DONE) & reqValid & ~flush);
  assign reqReady  = rspValid & rspReady;
  assign handshake = rspValid & rspReady;

  always_comb begin
    if (useSpecial)    resSel = SEL_SPECIAL;
    else if (useReuse) resSel = SEL_REUSE;
    else               resSel = SEL_CALC;
  end

  assign strobes.load   = start;
  assign strobes.step   = (state == ST_BUSY) && (cnt < CNT_W'(DATA_W));
  assign strobes.fix    = (state == ST_BUSY) && (cnt == CNT_W'(DATA_W));
  assign strobes.finish = (state == ST_BUSY) && (cnt == CNT_W'(LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_BUSY;
          cnt   <= '0;
        end
        ST_BUSY: begin
          if (flush)                         state <= ST_IDLE;
          else if (cnt == CNT_W'(LAST))      state <= ST_DONE;
          cnt <= cnt + 1'b1;
        end
        ST_DONE: if (flush || handshake) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  reuseOk <= 1'b0;
    else if (flush)                              reuseOk <= 1'b0;
    else if ((state == ST_DONE) && handshake)    reuseOk <= 1'b1;
  end

endmodule

// File: rtl/int_div_dp.sv
`timescale 1ns/1ps
module int_div_dp
  import int_div_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] reqDividend,
  input  logic [DATA_W-1:0] reqDivisor,
  input  logic [3:0]        reqOp,
  input  divStrobes_t       strobes,
  input  resSel_t           resSel,
  output logic              isSpecial,
  output logic [DATA_W-1:0] rspData
);
  localparam int PW = DATA_W + 2;
  localparam logic [DATA_W-1:0] MIN_VAL = {1'b1, {(DATA_W-1){1'b0}}};

  logic isSigned, isRem, sgnA, sgnB, divZero, overflow;
  logic [DATA_W-1:0] magA, magB, specialData;
  logic [PW-1:0] partRem, divMag, shifted, stepRem;
  logic [DATA_W-1:0] quoAcc, quotReg, remReg;
  logic negQ, negR, latchRem;

  assign isSigned = reqOp[0] | reqOp[2];
  assign isRem    = reqOp[2] | reqOp[3];
  assign sgnA     = isSigned & reqDividend[DATA_W-1];
  assign sgnB     = isSigned & reqDivisor[DATA_W-1];
  assign magA     = sgnA ? (~reqDividend + 1'b1) : reqDividend;
  assign magB     = sgnB ? (~reqDivisor + 1'b1) : reqDivisor;

  assign divZero  = (reqDivisor == '0);
  assign overflow = isSigned && (reqDividend == MIN_VAL) && (&reqDivisor);
  assign isSpecial = (|reqOp) && (divZero || overflow);

  always_comb begin
    if (divZero) specialData = isRem ? reqDividend : '1;
    else         specialData = isRem ? '0 : MIN_VAL;
  end

  assign shifted = {partRem[PW-2:0], quoAcc[DATA_W-1]};
  assign stepRem = partRem[PW-1] ? (shifted + divMag) : (shifted - divMag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      partRem  <= '0;
      quoAcc   <= '0;
      divMag   <= '0;
      negQ     <= 1'b0;
      negR     <= 1'b0;
      latchRem <= 1'b0;
      quotReg  <= '0;
      remReg   <= '0;
    end else begin
      if (strobes.load) begin
        partRem  <= '0;
        quoAcc   <= magA;
        divMag   <= {2'b00, magB};
        negQ     <= sgnA ^ sgnB;
        negR     <= sgnA;
        latchRem <= isRem;
      end else if (strobes.step) begin
        partRem <= stepRem;
        quoAcc  <= {quoAcc[DATA_W-2:0], ~stepRem[PW-1]};
      end else if (strobes.fix) begin
        if (partRem[PW-1]) partRem <= partRem + divMag;
      end
      if (strobes.finish) begin
        quotReg <= negQ ? (~quoAcc + 1'b1) : quoAcc;
        remReg  <= negR ? (~partRem[DATA_W-1:0] + 1'b1) : partRem[DATA_W-1:0];
      end
    end
  end

  always_comb begin
    case (resSel)
      SEL_SPECIAL: rspData = specialData;
      SEL_REUSE:   rspData = isRem ? remReg : quotReg;
      default:     rspData = latchRem ? remReg : quotReg;
    endcase
  end

endmodule

// File: rtl/int_divider.sv
`timescale 1ns/1ps
module int_divider
  import int_div_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [DATA_W-1:0] reqDividend,
  input  logic [DATA_W-1:0] reqDivisor,
  input  logic [3:0]        reqOp,
  input  logic              reqChain,
  input  logic              flush,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [DATA_W-1:0] rspData
);
  divStrobes_t strobes;
  resSel_t     resSel;
  divState_t   ctrlState;
  logic        isSpecial;

  int_div_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqChain(reqChain),
    .isSpecial(isSpecial), .flush(flush), .rspReady(rspReady),
    .strobes(strobes), .resSel(resSel), .rspValid(rspValid),
    .reqReady(reqReady), .state(ctrlState)
  );

  int_div_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .reqDividend(reqDividend), .reqDivisor(reqDivisor),
    .reqOp(reqOp), .strobes(strobes), .resSel(resSel),
    .isSpecial(isSpecial), .rspData(rspData)
  );

endmodule

// File: rtl/int_divider_checker.sv
`timescale 1ns/1ps
module int_divider_checker
  import int_div_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqValid,
  input logic              reqReady,
  input logic [DATA_W-1:0] reqDivisor,
  input logic [3:0]        reqOp,
  input logic              flush,
  input logic              rspValid,
  input logic              rspReady,
  input logic [DATA_W-1:0] rspData,
  input divState_t         state
);
  logic [7:0] busyRun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 busyRun <= '0;
    else if (state == ST_BUSY)  busyRun <= busyRun + 1'b1;
    else                        busyRun <= '0;
  end

  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE && $past(state) == ST_BUSY) |-> busyRun == 8'(DATA_W + 2));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE && !(rspValid && rspReady) && !flush) |=> (state == ST_DONE && $stable(rspData)));

  a_r7_ready: assert property (@(posedge clk) disable iff (!rst_n)
    reqReady |-> (rspValid && rspReady));

  a_r8_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !rspValid);

  a_r8_flush_idle: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> state == ST_IDLE);

  a_r4_zero_divu: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !flush && state == ST_IDLE && reqDivisor == '0 && reqOp == 4'b0010)
      |-> (rspValid && rspData == '1));

  a_r11_valid_req: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |-> reqValid);

endmodule

bind int_divider int_divider_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
  .reqDivisor(reqDivisor), .reqOp(reqOp), .flush(flush), .rspValid(rspValid),
  .rspReady(rspReady), .rspData(rspData), .state(ctrlState)
);

// File: tb/int_divider_bench.sv
`timescale 1ns/1ps
module int_divider_bench;
  localparam int W = 32;
  localparam int LAT = 36;
  localparam logic [3:0] OP_DIV = 4'b0001, OP_DIVU = 4'b0010, OP_REM = 4'b0100, OP_REMU = 4'b1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0, reqChain = 1'b0, flush = 1'b0, rspReady = 1'b0;
  logic [W-1:0] reqDividend = '0, reqDivisor = '0;
  logic [3:0] reqOp = '0;
  logic reqReady, rspValid;
  logic [W-1:0] rspData;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit mReuse = 1'b0;
  logic [W-1:0] mQuot = '0, mRem = '0;

  always #10 clk = ~clk;

  int_divider #(.DATA_W(W)) u_int_divider (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqDividend(reqDividend), .reqDivisor(reqDivisor), .reqOp(reqOp),
    .reqChain(reqChain), .flush(flush), .rspValid(rspValid),
    .rspReady(rspReady), .rspData(rspData)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic void refQR(input logic sgn, input logic [W-1:0] a, input logic [W-1:0] b,
                                output logic [W-1:0] q, output logic [W-1:0] r);
    longint sa, sb;
    if (b == 0) begin
      q = '1; r = a;
    end else if (sgn && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
      q = a; r = '0;
    end else if (sgn) begin
      sa = longint'($signed(a)); sb = longint'($signed(b));
      q = W'(sa / sb); r = W'(sa % sb);
    end else begin
      q = a / b; r = a % b;
    end
  endfunction

  task automatic runOp(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic chain, input int stall, input string tag);
    logic sgn, rem, special, reuse;
    logic [W-1:0] q, r, exp;
    int lat;
    sgn = op[0] | op[2];
    rem = op[2] | op[3];
    refQR(sgn, a, b, q, r);
    special = (b == 0) || (sgn && a == 32'h8000_0000 && b == 32'hFFFF_FFFF);
    reuse = !special && chain && mReuse;
    exp = reuse ? (rem ? mRem : mQuot) : (rem ? r : q);
    lat = (special || reuse) ? 1 : LAT;
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqDividend = a; reqDivisor = b; reqChain = chain;
    rspReady = (stall == 0);
    for (int c = 1; c <= lat; c++) begin
      #1;
      check({tag, " R3 valid timing"}, W'(rspValid), W'(c == lat));
      if (c < lat) @(negedge clk);
    end
    check({tag, " data"}, rspData, exp);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk); #1;
      check("R7 held valid", W'(rspValid), 1);
      check("R7 held data", rspData, exp);
      check("R7 no ready while stalled", W'(reqReady), 0);
    end
    rspReady = 1'b1; #1;
    check("R7 reqReady at handshake", W'(reqReady), 1);
    @(negedge clk);
    reqValid = 1'b0; rspReady = 1'b0; reqChain = 1'b0; #1;
    check("R11 no valid after retire", W'(rspValid), 0);
    if (!special && !reuse) begin
      mReuse = 1'b1; mQuot = q; mRem = r;
    end
  endtask

  task automatic runFlush(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                          input int after);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqDividend = a; reqDivisor = b; reqChain = 1'b0;
    rspReady = 1'b0;
    for (int c = 1; c <= after; c++) begin
      #1;
      check("R3 valid before flush", W'(rspValid), W'(c >= LAT));
      @(negedge clk);
    end
    flush = 1'b1; #1;
    check("R8 no valid in flush cycle", W'(rspValid), 0);
    @(negedge clk);
    flush = 1'b0; reqValid = 1'b0; #1;
    check("R8 no result after flush", W'(rspValid), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      check("R8 still quiet", W'(rspValid), 0);
    end
    mReuse = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R11 reset rspValid", W'(rspValid), 0);
    check("R11 reset reqReady", W'(reqReady), 0);

    runOp(OP_DIVU, 100, 7, 1'b0, 0, "R1 divu");
    runOp(OP_REMU, 100, 7, 1'b0, 0, "R2 remu");
    runOp(OP_DIV, -32'sd100, 7, 1'b0, 0, "R1 div neg dividend");
    runOp(OP_REM, -32'sd100, 7, 1'b0, 0, "R2 rem neg dividend");
    runOp(OP_DIV, 100, -32'sd7, 1'b0, 0, "R1 div neg divisor");
    runOp(OP_REM, 7, -32'sd100, 1'b0, 0, "R2 rem small");
    runOp(OP_DIVU, 32'hFFFF_FFFF, 1, 1'b0, 0, "R1 divu max");
    runOp(OP_REMU, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 1'b0, 0, "R2 remu large");

    runOp(OP_DIV, 1234, 0, 1'b0, 0, "R4 R6 div zero");
    runOp(OP_DIVU, 55, 0, 1'b0, 0, "R4 R6 divu zero");
    runOp(OP_REM, -32'sd9, 0, 1'b0, 0, "R4 R6 rem zero");
    runOp(OP_REMU, 32'hDEAD_BEEF, 0, 1'b0, 0, "R4 R6 remu zero");
    runOp(OP_DIV, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 0, "R5 R6 div overflow");
    runOp(OP_REM, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 0, "R5 R6 rem overflow");
    runOp(OP_DIVU, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 0, "R5 divu no shortcut");

    runOp(OP_REM, 1000, 33, 1'b0, 0, "R9 setup");
    runOp(OP_DIV, 1000, 33, 1'b1, 0, "R9 chained quotient");
    runOp(OP_REMU, 1000, 33, 1'b1, 0, "R9 chained remainder");

    runOp(OP_DIV, -32'sd77777, 123, 1'b0, 4, "R7 stall");

    runFlush(OP_DIVU, 99999, 13, 10);
    runOp(OP_DIVU, 99999, 13, 1'b1, 0, "R10 chained after busy flush");
    runFlush(OP_REM, 5000, 7, 40);
    runOp(OP_REM, 5000, 7, 1'b1, 0, "R10 chained after done flush");

    for (int i = 0; i < 20; i++) begin
      logic [3:0] op;
      logic [W-1:0] a, b;
      op = 4'b0001 << (i % 4);
      a = $urandom;
      b = (i % 3 == 0) ? W'($urandom % 50 + 1) : $urandom;
      runOp(op, a, b, 1'b0, i % 2, "R1 R2 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule